// File: doc/BRIEF.md
# Bit-Serial Accumulating Adder

This block sums a stream of small unsigned numbers using a single one-bit full adder and a carry flip-flop. A parallel adder would need one full adder per bit. The running total sits in an accumulator register. The operand sits in a second register, and both registers shift right by one bit on every enabled clock. On each of those clocks their low bits and the stored carry feed the full adder. The sum bit goes back into the accumulator at its top end, and the carry-out is stored for the next bit.

The operand register has a serial input. While one operand is being consumed, the next one arrives on that input, least significant bit first, during the same clocks. Numbers can therefore be streamed back to back with no idle gap, and the total builds up in the accumulator. An addition of a `W`-bit operand takes `W` enabled clocks. A one-cycle strobe marks the end of each group of `W` shifts. At that point the carry is dropped, so the total wraps modulo 2^W.

The first group after a clear adds zero, because the operand register starts empty. So the accumulator always trails the input stream by one operand.

Top module: `serial_accum_adder`

## Requirements
- R1: A clock with `clr` high sets the accumulator, the operand register, the carry flip-flop, the bit counter and `done` to zero. `clr` takes priority over `shift_en`.
- R2: On each clock with `shift_en` high, `ser_in` enters the operand register at its most significant bit. An operand is therefore supplied least significant bit first over `W` consecutive shifts.
- R3: After each group of `W` shifts, `acc_q` equals its value at the start of the group plus the operand loaded during the previous group, modulo 2^W. For the first group after a clear, that operand is zero.
- R4: Operands streamed with no gaps accumulate. At the k-th `done` after a clear, `acc_q` equals the sum of the first k-1 operands modulo 2^W.
- R5: `done` is high for exactly one cycle, in the cycle that follows the W-th shift of each group. It is low at all other times.
- R6: The carry flip-flop is cleared at the end of each group, so every addition starts with a carry-in of 0.
- R7: A carry out of the top bit is discarded, so the sum wraps. For example, 15 + 1 gives 0 with W=4.
- R8: While `shift_en` is low, `acc_q`, the operand register, the carry and the bit counter all keep their values. A paused group resumes where it stopped.
- R9: On each shift, `acc_q` moves right by one bit and the new sum bit enters at bit W-1. After j shifts of a group, the top j bits hold the low j bits of the sum, and the low W-j bits hold the starting accumulator value shifted right by j.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| clr | input | 1 | Synchronous active-high clear of all state |
| shift_en | input | 1 | Advance one bit of the serial addition |
| ser_in | input | 1 | Serial operand bit, least significant first |
| acc_q | output | W | Accumulator contents (registered) |
| done | output | 1 | One-cycle strobe after each W-bit addition |

## Verification
The stream includes 15 followed by 1 and then 0. A design that keeps the carry-out, or fails to drop the carry at the group boundary, would show 1 instead of 0 in the last sum. Pauses are placed in the middle of a group. A design that lets the counter or the carry drift while `shift_en` is low would misalign every later operand, and the sums would come out shifted. The accumulator is compared after every single shift, against the mix of sum bits and old bits that R9 predicts. A reversed shift direction, or a sum bit placed in the wrong position, would show up before the group completes. A clear in the middle of a stream confirms that a partly loaded operand is discarded: the next group must add zero.

// File: rtl/serial_adder_pkg.sv
package serial_adder_pkg;

  typedef struct packed {
    logic sum;
    logic cout;
  } fa_out_t;

  function automatic fa_out_t full_add(input logic x, input logic y, input logic cin);
    fa_out_t r;
    r.sum  = x ^ y ^ cin;
    r.cout = (x & y) | (x & cin) | (y & cin);
    return r;
  endfunction

endpackage

// File: rtl/sa_shift_reg.sv
module sa_shift_reg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         en,
  input  logic         sin,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (clr)
      q <= '0;
    else if (en)
      q <= {sin, q[W-1:1]};
  end

endmodule

// File: rtl/sa_bit_slice.sv
module sa_bit_slice
  import serial_adder_pkg::*;
(
  input  logic clk,
  input  logic clr,
  input  logic en,
  input  logic last,
  input  logic a_bit,
  input  logic b_bit,
  output logic sum_bit,
  output logic carry_q
);

  fa_out_t fa;

  always_comb fa = full_add(a_bit, b_bit, carry_q);

  assign sum_bit = fa.sum;

  always_ff @(posedge clk) begin
    if (clr)
      carry_q <= 1'b0;
    else if (en)
      carry_q <= last ? 1'b0 : fa.cout;
  end

endmodule

// File: rtl/sa_bit_counter.sv
module sa_bit_counter #(
  parameter int W  = 4,
  localparam int CW = $clog2(W)
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          en,
  output logic [CW-1:0] cnt,
  output logic          last
);

  localparam logic [CW-1:0] TOP = CW'(W - 1);

  assign last = en && (cnt == TOP);

  always_ff @(posedge clk) begin
    if (clr)
      cnt <= '0;
    else if (en)
      cnt <= (cnt == TOP) ? '0 : cnt + 1'b1;
  end

endmodule

// File: rtl/serial_accum_adder.sv
module serial_accum_adder #(
  parameter int W = 4,
  localparam int CW = $clog2(W)
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         shift_en,
  input  logic         ser_in,
  output logic [W-1:0] acc_q,
  output logic         done
);

  logic [W-1:0]  a_q;
  logic [W-1:0]  b_q;
  logic [CW-1:0] cnt;
  logic          last;
  logic          sum_bit;
  logic          carry_q;
  logic          unused_b_hi;

  assign unused_b_hi = ^b_q[W-1:1];

  sa_bit_counter #(.W(W)) u_cnt (
    .clk  (clk),
    .clr  (clr),
    .en   (shift_en),
    .cnt  (cnt),
    .last (last)
  );

  sa_shift_reg #(.W(W)) u_areg (
    .clk (clk),
    .clr (clr),
    .en  (shift_en),
    .sin (sum_bit),
    .q   (a_q)
  );

  sa_shift_reg #(.W(W)) u_breg (
    .clk (clk),
    .clr (clr),
    .en  (shift_en),
    .sin (ser_in),
    .q   (b_q)
  );

  sa_bit_slice u_slice (
    .clk     (clk),
    .clr     (clr),
    .en      (shift_en),
    .last    (last),
    .a_bit   (a_q[0]),
    .b_bit   (b_q[0]),
    .sum_bit (sum_bit),
    .carry_q (carry_q)
  );

  always_ff @(posedge clk) begin
    if (clr)
      done <= 1'b0;
    else
      done <= last;
  end

  assign acc_q = a_q;

endmodule

// File: rtl/sa_checker.sv
module sa_checker #(
  parameter int W = 4,
  localparam int CW = $clog2(W)
) (
  input logic          clk,
  input logic          clr,
  input logic          shift_en,
  input logic [W-1:0]  acc_q,
  input logic          done,
  input logic          carry_q,
  input logic [CW-1:0] cnt
);

  p_clear_r1: assert property (@(posedge clk)
    clr |=> (acc_q == '0 && !done && !carry_q && cnt == '0));

  p_done_single_r5: assert property (@(posedge clk) disable iff (clr)
    done |=> !done);

  p_done_source_r5: assert property (@(posedge clk) disable iff (clr)
    done |-> ($past(shift_en) && $past(cnt) == CW'(W - 1)));

  p_carry_reset_r6: assert property (@(posedge clk) disable iff (clr)
    done |-> !carry_q);

  p_hold_acc_r8: assert property (@(posedge clk) disable iff (clr)
    !shift_en |=> $stable(acc_q));

  p_hold_cnt_r8: assert property (@(posedge clk) disable iff (clr)
    !shift_en |=> ($stable(cnt) && $stable(carry_q)));

  p_shift_right_r9: assert property (@(posedge clk) disable iff (clr)
    shift_en |=> acc_q[W-2:0] == $past(acc_q[W-1:1]));

endmodule

bind serial_accum_adder sa_checker #(.W(W)) u_chk (
  .clk      (clk),
  .clr      (clr),
  .shift_en (shift_en),
  .acc_q    (acc_q),
  .done     (done),
  .carry_q  (carry_q),
  .cnt      (cnt)
);

// File: tb/serial_accum_adder_tb.sv
`timescale 1ns/1ps
module serial_accum_adder_tb;

  localparam int W = 4;
  localparam int MASK = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         clr = 1'b1;
  logic         shift_en = 1'b0;
  logic         ser_in = 1'b0;
  logic [W-1:0] acc_q;
  logic         done;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [W:0] exp_q[$];
  string      tag_q[$];

  int m_acc = 0;
  int grp_a0 = 0;
  int grp_b = 0;
  int load_val = 0;
  int j = 0;

  always #4 clk = ~clk;

  serial_accum_adder #(.W(W)) u_dut (
    .clk      (clk),
    .clr      (clr),
    .shift_en (shift_en),
    .ser_in   (ser_in),
    .acc_q    (acc_q),
    .done     (done)
  );

  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      logic [W:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      total++;
      if ({done, acc_q} !== e) begin
        bad++;
        $display("FAIL %s: done/acc actual=%0b/%0d expected=%0b/%0d",
                 t, done, acc_q, e[W], e[W-1:0]);
      end
    end
  end

  task automatic push(input int acc, input bit d, input string t);
    exp_q.push_back({d, W'(acc)});
    tag_q.push_back(t);
  endtask

  task automatic do_clear();
    @(negedge clk);
    clr = 1'b1; shift_en = 1'b0; ser_in = 1'b0;
    m_acc = 0; grp_a0 = 0; grp_b = 0; load_val = 0; j = 0;
    push(0, 1'b0, "R1");
  endtask

  task automatic idle();
    @(negedge clk);
    clr = 1'b0; shift_en = 1'b0; ser_in = 1'b1;
    push(m_acc, 1'b0, "R8");
  endtask

  task automatic shift_bit(input bit b);
    int s;
    @(negedge clk);
    clr = 1'b0; shift_en = 1'b1; ser_in = b;
    j++;
    s = (grp_a0 + grp_b) & MASK;
    load_val |= int'(b) << (j - 1);
    m_acc = ((s << (W - j)) | (grp_a0 >> j)) & MASK;
    if (j == W) begin
      push(m_acc, 1'b1, "R3/R4/R5");
      grp_a0 = s; grp_b = load_val; load_val = 0; j = 0;
    end else begin
      push(m_acc, 1'b0, "R9");
    end
  endtask

  task automatic send(input int v);
    for (int i = 0; i < W; i++) shift_bit(v[i]);
  endtask

  initial begin
    do_clear();
    do_clear();
    idle();
    // R2 R3 R4: streamed operands, first group adds zero
    send(3); send(5); send(9); send(2);
    // R8: pauses inside a group
    shift_bit(1'b1); idle(); idle(); shift_bit(1'b0); idle();
    shift_bit(1'b0); shift_bit(1'b0);
    // R7 R6: 15 + 1 wraps to 0, then +0 must stay 0
    do_clear();
    send(15); send(1); send(0); send(0); send(7);
    // R6: carry-heavy pairs
    send(11); send(13); send(6); send(0);
    // R1: clear mid-stream discards partial operand
    shift_bit(1'b1); shift_bit(1'b1);
    do_clear();
    send(0); send(4); send(12); send(0);
    idle(); idle();
    repeat (3) @(posedge clk);
    #3;
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 8);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule